// File: doc/BRIEF.md
# Holdover History Manager

This block keeps the frequency-control history used by an oscillator disciplining loop when its reference goes away. It holds three pieces of state: an active history word, a backup history word and an accumulator that builds a fresh history. Once the loop reports lock on a reference, the block averages a power-of-two number of control-word samples, one per timebase tick, into a new history. It then copies that average into the active word and afterwards tracks the reference with a first-order exponential average. The active word is always presented as the holdover frequency word, so entering holdover needs no switch-over.

Software steers the history through three command strobes: save, restore and flush. A policy input decides what happens after a reference switch. Under rebuild, a full build period is run. Under continue, an available history is adopted at once. A saturating hour counter measures time spent in holdover, derived from the same tick.

Top module: `holdover_history_mgr`

## Requirements
- R1: While rst_n is low, the active and backup words both take the FREERUN parameter value, build_done and hist_avail are 0 and holdover_hours is 0.
- R2: A cmd_save strobe makes backup_word equal, after the next clock edge, the active value that results from that same cycle.
- R3: A cmd_restore strobe copies the backup word into the active word at the next clock edge, in any state including holdover, and holdover_word shows it from that edge on.
- R4: A cmd_flush strobe sets the active word back to FREERUN, clears hist_avail and build_done, discards any build in progress and leaves the backup word unchanged.
- R5: Strobes in the same cycle apply in the order flush, then restore, then save.
- R6: holdover_word always equals the active history word; no other value reaches it.
- R7: Under the rebuild policy (policy_continue = 0), a build starts in the cycle after lock is seen with in_holdover low. It sums the sample on each of the next 2^LOG2N ticks, writes sum >> LOG2N into the active word and sets build_done and hist_avail in the cycle of the last tick.
- R8: A ref_switch pulse clears build_done and returns the builder to waiting for lock; the active word and hist_avail remain unchanged.
- R9: Under the continue policy (policy_continue = 1) with hist_avail = 1, build_done is set one edge after lock is seen and the active word is kept. With hist_avail = 0, a full build runs as in R7.
- R10: After a build completes, each tick while locked and not in holdover updates the active word a to a + floor((sample - a) / 2^TRACK_SHIFT).
- R11: holdover_hours counts one per TICKS_PER_HOUR ticks while in_holdover is 1, saturates at 255, and is 0 whenever in_holdover is 0.
- R12: No accumulation happens while locked is 0 or in_holdover is 1. Losing lock or entering holdover during a build abandons it, and the next build starts again from zero samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase tick, one cycle wide; paces sampling and the hour counter |
| sample_word | input | W | Control word from the loop filter, taken on ticks |
| locked | input | 1 | Loop is locked to the current reference |
| ref_switch | input | 1 | One-cycle pulse marking a change of reference |
| in_holdover | input | 1 | Loop is in holdover |
| policy_continue | input | 1 | 1 = continue policy, 0 = rebuild policy |
| cmd_save | input | 1 | Strobe: copy active to backup |
| cmd_restore | input | 1 | Strobe: copy backup to active |
| cmd_flush | input | 1 | Strobe: clear active history and accumulator |
| holdover_word | output | W | Active history word used as the holdover frequency |
| backup_word | output | W | Backup history word |
| hist_avail | output | 1 | An active history has been built since the last flush |
| build_done | output | 1 | A build has completed on the current reference |
| holdover_hours | output | 8 | Hours spent in holdover, saturating at 255 |

## Verification
The assertions assume that ref_switch and the command strobes are single-cycle events sampled on clock edges, and that tick is at most one cycle wide per timebase period. Checks relating hour steps and build aborts also assume that locked and in_holdover are level signals that the block does not itself produce. The random stimulus keeps lock and holdover in multi-cycle runs and fires strobes and ticks as independent per-cycle draws. Because the strobes are draws and not held levels, the same-cycle command combinations of R5 arise without violating these assumptions.

// File: rtl/hhm_pkg.sv
package hhm_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_BUILD = 2'd1,
        ST_TRACK = 2'd2
    } bld_state_e;

endpackage

// File: rtl/hhm_builder.sv
module hhm_builder
    import hhm_pkg::*;
#(
    parameter int W           = 16,
    parameter int LOG2N       = 3,
    parameter int TRACK_SHIFT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] sample,
    input  logic         locked,
    input  logic         in_holdover,
    input  logic         ref_switch,
    input  logic         flush,
    input  logic         policy_continue,
    input  logic [W-1:0] active_word,
    output logic         wr_en,
    output logic [W-1:0] wr_val,
    output logic         build_done,
    output logic         hist_avail
);

    localparam int SUM_W = W + LOG2N;
    localparam int CNT_W = LOG2N + 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'((1 << LOG2N) - 1);

    typedef struct packed {
        bld_state_e       st;
        logic [SUM_W-1:0] sum;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             avail;
    } bld_regs_t;

    localparam bld_regs_t RST_VAL = '{st: ST_WAIT, sum: '0, cnt: '0, done: 1'b0, avail: 1'b0};

    bld_regs_t r_q, r_d;

    logic              run_ok;
    logic [SUM_W-1:0]  sum_next;
    logic [W-1:0]      avg_val;
    logic signed [W+1:0] diff, step, trk_sum;
    logic [W-1:0]      trk_val;

    always_comb begin
        run_ok   = locked && !in_holdover;
        sum_next = r_q.sum + SUM_W'(sample);
        avg_val  = sum_next[SUM_W-1:LOG2N];
        diff     = $signed({2'b00, sample}) - $signed({2'b00, active_word});
        step     = diff >>> TRACK_SHIFT;
        trk_sum  = $signed({2'b00, active_word}) + step;
        trk_val  = trk_sum[W-1:0];

        r_d    = r_q;
        wr_en  = 1'b0;
        wr_val = active_word;

        if (flush) begin
            r_d.st    = ST_WAIT;
            r_d.sum   = '0;
            r_d.cnt   = '0;
            r_d.done  = 1'b0;
            r_d.avail = 1'b0;
        end else if (ref_switch) begin
            r_d.st   = ST_WAIT;
            r_d.sum  = '0;
            r_d.cnt  = '0;
            r_d.done = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_WAIT: begin
                    if (run_ok) begin
                        if (policy_continue && r_q.avail) begin
                            r_d.st   = ST_TRACK;
                            r_d.done = 1'b1;
                        end else begin
                            r_d.st  = ST_BUILD;
                            r_d.sum = '0;
                            r_d.cnt = '0;
                        end
                    end
                end
                ST_BUILD: begin
                    if (!run_ok) begin
                        r_d.st  = ST_WAIT;
                        r_d.sum = '0;
                        r_d.cnt = '0;
                    end else if (tick) begin
                        if (r_q.cnt == LAST_CNT) begin
                            wr_en     = 1'b1;
                            wr_val    = avg_val;
                            r_d.st    = ST_TRACK;
                            r_d.sum   = '0;
                            r_d.cnt   = '0;
                            r_d.done  = 1'b1;
                            r_d.avail = 1'b1;
                        end else begin
                            r_d.sum = sum_next;
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                ST_TRACK: begin
                    if (tick && run_ok) begin
                        wr_en  = 1'b1;
                        wr_val = trk_val;
                    end
                end
                default: r_d = RST_VAL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST_VAL;
        else        r_q <= r_d;
    end

    assign build_done = r_q.done;
    assign hist_avail = r_q.avail;

    // R12: no build can be running after a cycle without lock or in holdover
    assert_no_build_unlocked_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked || in_holdover) |=> (r_q.st != ST_BUILD));

    // R7: a completed build always implies an available history
    assert_done_has_avail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> r_q.avail);

    // R8: a reference switch keeps availability and clears completion
    assert_switch_keeps_avail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_switch && !flush) |=> (!r_q.done && (r_q.avail == $past(r_q.avail))));

endmodule

// File: rtl/hhm_hist_store.sv
module hhm_hist_store #(
    parameter int           W       = 16,
    parameter logic [W-1:0] FREERUN = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         cmd_save,
    input  logic         cmd_restore,
    input  logic         cmd_flush,
    output logic [W-1:0] active_word,
    output logic [W-1:0] backup_word
);

    typedef struct packed {
        logic [W-1:0] active;
        logic [W-1:0] backup;
    } hist_regs_t;

    hist_regs_t h_q, h_d;

    always_comb begin
        h_d = h_q;
        if (wr_en)       h_d.active = wr_val;
        if (cmd_flush)   h_d.active = FREERUN;
        if (cmd_restore) h_d.active = h_q.backup;
        if (cmd_save)    h_d.backup = h_d.active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q.active <= FREERUN;
            h_q.backup <= FREERUN;
        end else begin
            h_q <= h_d;
        end
    end

    assign active_word = h_q.active;
    assign backup_word = h_q.backup;

    // R3: restore lands the old backup in the active word
    assert_restore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_restore |=> (active_word == $past(backup_word)));

    // R2: a lone save captures the active word when nothing else changes it
    assert_save_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_save && !cmd_restore && !cmd_flush && !wr_en) |=> (backup_word == $past(active_word)));

    // R4: flush never disturbs the backup
    assert_flush_keeps_backup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_flush && !cmd_save) |=> (backup_word == $past(backup_word)));

endmodule

// File: rtl/hhm_hold_timer.sv
module hhm_hold_timer #(
    parameter int TICKS_PER_HOUR = 4,
    parameter int HOURS_W        = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               in_holdover,
    output logic [HOURS_W-1:0] hours
);

    localparam int PRE_W = (TICKS_PER_HOUR > 1) ? $clog2(TICKS_PER_HOUR) : 1;
    localparam logic [PRE_W-1:0]   PRE_LAST = PRE_W'(TICKS_PER_HOUR - 1);
    localparam logic [HOURS_W-1:0] HOURS_MAX = '1;

    typedef struct packed {
        logic [PRE_W-1:0]   pre;
        logic [HOURS_W-1:0] hrs;
    } tmr_regs_t;

    tmr_regs_t t_q, t_d;

    always_comb begin
        t_d = t_q;
        if (!in_holdover) begin
            t_d.pre = '0;
            t_d.hrs = '0;
        end else if (tick) begin
            if (t_q.pre == PRE_LAST) begin
                t_d.pre = '0;
                if (t_q.hrs != HOURS_MAX) t_d.hrs = t_q.hrs + 1'b1;
            end else begin
                t_d.pre = t_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign hours = t_q.hrs;

    // R11: the count is zero after any cycle outside holdover
    assert_hours_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_holdover |=> (hours == '0));

    // R11: inside holdover the count holds or steps by one
    assert_hours_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_holdover |=> ((hours == $past(hours)) || (hours == $past(hours) + 1'b1)));

endmodule

// File: rtl/holdover_history_mgr.sv
module holdover_history_mgr #(
    parameter int           W              = 16,
    parameter int           LOG2N          = 3,
    parameter int           TRACK_SHIFT    = 2,
    parameter int           TICKS_PER_HOUR = 4,
    parameter logic [W-1:0] FREERUN        = 16'h8000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] sample_word,
    input  logic         locked,
    input  logic         ref_switch,
    input  logic         in_holdover,
    input  logic         policy_continue,
    input  logic         cmd_save,
    input  logic         cmd_restore,
    input  logic         cmd_flush,
    output logic [W-1:0] holdover_word,
    output logic [W-1:0] backup_word,
    output logic         hist_avail,
    output logic         build_done,
    output logic [7:0]   holdover_hours
);

    logic         wr_en;
    logic [W-1:0] wr_val;
    logic [W-1:0] active_word;

    hhm_builder #(
        .W           (W),
        .LOG2N       (LOG2N),
        .TRACK_SHIFT (TRACK_SHIFT)
    ) u_builder (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick            (tick),
        .sample          (sample_word),
        .locked          (locked),
        .in_holdover     (in_holdover),
        .ref_switch      (ref_switch),
        .flush           (cmd_flush),
        .policy_continue (policy_continue),
        .active_word     (active_word),
        .wr_en           (wr_en),
        .wr_val          (wr_val),
        .build_done      (build_done),
        .hist_avail      (hist_avail)
    );

    hhm_hist_store #(
        .W       (W),
        .FREERUN (FREERUN)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_val      (wr_val),
        .cmd_save    (cmd_save),
        .cmd_restore (cmd_restore),
        .cmd_flush   (cmd_flush),
        .active_word (active_word),
        .backup_word (backup_word)
    );

    hhm_hold_timer #(
        .TICKS_PER_HOUR (TICKS_PER_HOUR),
        .HOURS_W        (8)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .in_holdover (in_holdover),
        .hours       (holdover_hours)
    );

    assign holdover_word = active_word;

    // R6: the holdover output moves only on a build write or a command
    assert_word_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !cmd_flush && !cmd_restore) |=> $stable(holdover_word));

endmodule

// File: tb/holdover_history_mgr_tb.sv
module holdover_history_mgr_tb;

    localparam int          W    = 16;
    localparam int          L2N  = 3;
    localparam int          K    = 2;
    localparam int          TPH  = 4;
    localparam logic [15:0] FREE = 16'h8000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick, locked, ref_switch, in_holdover, policy_continue;
    logic        cmd_save, cmd_restore, cmd_flush;
    logic [15:0] sample_word;
    logic [15:0] holdover_word, backup_word;
    logic        hist_avail, build_done;
    logic [7:0]  holdover_hours;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference model state
    logic [15:0] m_act, m_bak;
    int          m_st, m_sum, m_cnt, m_pre, m_hrs;
    logic        m_done, m_avail;

    always #5 clk = ~clk;

    holdover_history_mgr #(
        .W(W), .LOG2N(L2N), .TRACK_SHIFT(K), .TICKS_PER_HOUR(TPH), .FREERUN(FREE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sample_word(sample_word),
        .locked(locked), .ref_switch(ref_switch), .in_holdover(in_holdover),
        .policy_continue(policy_continue), .cmd_save(cmd_save),
        .cmd_restore(cmd_restore), .cmd_flush(cmd_flush),
        .holdover_word(holdover_word), .backup_word(backup_word),
        .hist_avail(hist_avail), .build_done(build_done),
        .holdover_hours(holdover_hours)
    );

    function automatic logic [15:0] f_track(logic [15:0] a, logic [15:0] s);
        int d;
        d = int'(s) - int'(a);
        d = d >>> K;
        return 16'(int'(a) + d);
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        m_act = FREE; m_bak = FREE; m_st = 0; m_sum = 0; m_cnt = 0;
        m_done = 1'b0; m_avail = 1'b0; m_pre = 0; m_hrs = 0;
    endtask

    task automatic model_step();
        logic        we;
        logic [15:0] wv, a_n;
        bit          ok;
        we = 1'b0; wv = m_act;
        ok = locked && !in_holdover;
        if (cmd_flush) begin
            m_st = 0; m_sum = 0; m_cnt = 0; m_done = 1'b0; m_avail = 1'b0;
        end else if (ref_switch) begin
            m_st = 0; m_sum = 0; m_cnt = 0; m_done = 1'b0;
        end else if (m_st == 0) begin
            if (ok) begin
                if (policy_continue && m_avail) begin m_st = 2; m_done = 1'b1; end
                else begin m_st = 1; m_sum = 0; m_cnt = 0; end
            end
        end else if (m_st == 1) begin
            if (!ok) begin m_st = 0; m_sum = 0; m_cnt = 0; end
            else if (tick) begin
                if (m_cnt == (1 << L2N) - 1) begin
                    we = 1'b1; wv = 16'((m_sum + int'(sample_word)) >> L2N);
                    m_st = 2; m_sum = 0; m_cnt = 0; m_done = 1'b1; m_avail = 1'b1;
                end else begin
                    m_sum = m_sum + int'(sample_word); m_cnt = m_cnt + 1;
                end
            end
        end else begin
            if (tick && ok) begin we = 1'b1; wv = f_track(m_act, sample_word); end
        end
        a_n = we ? wv : m_act;
        if (cmd_flush)   a_n = FREE;
        if (cmd_restore) a_n = m_bak;
        if (cmd_save)    m_bak = a_n;
        m_act = a_n;
        if (!in_holdover) begin m_pre = 0; m_hrs = 0; end
        else if (tick) begin
            if (m_pre == TPH - 1) begin m_pre = 0; if (m_hrs != 255) m_hrs = m_hrs + 1; end
            else m_pre = m_pre + 1;
        end
    endtask

    task automatic compare_all();
        chk("R6/R10 holdover_word", 32'(holdover_word), 32'(m_act));
        chk("R2 backup_word",       32'(backup_word),   32'(m_bak));
        chk("R7 build_done",        32'(build_done),    32'(m_done));
        chk("R9 hist_avail",        32'(hist_avail),    32'(m_avail));
        chk("R11 holdover_hours",   32'(holdover_hours), 32'(m_hrs));
    endtask

    task automatic step();
        model_step();
        @(negedge clk);
        compare_all();
        cmd_save = 1'b0; cmd_restore = 1'b0; cmd_flush = 1'b0; ref_switch = 1'b0;
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired got=0 exp=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tick = 1'b0; locked = 1'b0; ref_switch = 1'b0;
        in_holdover = 1'b0; policy_continue = 1'b0; cmd_save = 1'b0;
        cmd_restore = 1'b0; cmd_flush = 1'b0; sample_word = 16'h0;
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 active at reset", 32'(holdover_word), 32'(FREE));
        chk("R1 backup at reset", 32'(backup_word), 32'(FREE));
        chk("R1 flags at reset", {30'b0, build_done, hist_avail}, 32'h0);
        chk("R1 hours at reset", 32'(holdover_hours), 32'h0);
        rst_n = 1'b1;

        // R7 rebuild: 1 edge to start, 8 ticks to complete, 1 tracking tick
        locked = 1'b1; tick = 1'b1; sample_word = 16'h1000;
        steps(10);
        chk("R7 build average", 32'(holdover_word), 32'h1000);
        chk("R7 done and avail", {30'b0, build_done, hist_avail}, 32'h3);

        // R10 tracking step
        sample_word = 16'h2000; step();
        chk("R10 tracking update", 32'(holdover_word), 32'h1400);
        tick = 1'b0;

        // R2 save
        cmd_save = 1'b1; step();
        chk("R2 save copies active", 32'(backup_word), 32'h1400);

        // R8 reference switch
        ref_switch = 1'b1; locked = 1'b0; step(); step();
        chk("R8 done cleared", 32'(build_done), 32'h0);
        chk("R8 avail kept", 32'(hist_avail), 32'h1);
        chk("R8 active kept", 32'(holdover_word), 32'h1400);

        // R9 continue with available history
        policy_continue = 1'b1; locked = 1'b1; step();
        chk("R9 continue done at once", 32'(build_done), 32'h1);
        chk("R9 continue keeps active", 32'(holdover_word), 32'h1400);

        // R12 no update without lock
        locked = 1'b0; tick = 1'b1; sample_word = 16'hFFFF; steps(4);
        chk("R12 no update unlocked", 32'(holdover_word), 32'h1400);

        // R3 restore in holdover
        locked = 1'b1; sample_word = 16'h3400; step();
        chk("R10 second tracking step", 32'(holdover_word), 32'h1C00);
        tick = 1'b0; in_holdover = 1'b1; cmd_restore = 1'b1; step();
        chk("R3 restore in holdover", 32'(holdover_word), 32'h1400);

        // R11 hours
        tick = 1'b1; steps(12);
        chk("R11 three hours", 32'(holdover_hours), 32'd3);
        steps(1020);
        chk("R11 saturates at 255", 32'(holdover_hours), 32'd255);
        in_holdover = 1'b0; tick = 1'b0; step();
        chk("R11 zero outside holdover", 32'(holdover_hours), 32'd0);

        // R4 flush
        cmd_flush = 1'b1; step();
        chk("R4 flush active", 32'(holdover_word), 32'(FREE));
        chk("R4 flush flags", {30'b0, build_done, hist_avail}, 32'h0);
        chk("R4 flush keeps backup", 32'(backup_word), 32'h1400);

        // R5 priority
        locked = 1'b0;
        cmd_flush = 1'b1; cmd_restore = 1'b1; cmd_save = 1'b1; step();
        chk("R5 flush+restore+save active", 32'(holdover_word), 32'h1400);
        chk("R5 flush+restore+save backup", 32'(backup_word), 32'h1400);
        cmd_flush = 1'b1; cmd_save = 1'b1; step();
        chk("R5 flush+save active", 32'(holdover_word), 32'(FREE));
        chk("R5 flush+save backup", 32'(backup_word), 32'(FREE));

        // R9 continue without history behaves as rebuild; R12 abort restarts
        policy_continue = 1'b1; locked = 1'b1; tick = 1'b1; sample_word = 16'h0800;
        steps(4);
        chk("R9 no history means build", 32'(build_done), 32'h0);
        locked = 1'b0; steps(2);
        locked = 1'b1; steps(8);
        chk("R12 aborted build restarts", 32'(build_done), 32'h0);
        step();
        chk("R9 build completes", 32'(build_done), 32'h1);
        chk("R9 build average", 32'(holdover_word), 32'h0800);

        // random phase
        void'($urandom(32'd1234));
        for (int seg = 0; seg < 80; seg++) begin
            int mode;
            mode = $urandom % 6;
            locked      = (mode != 0);
            in_holdover = (mode == 1);
            if (($urandom % 4) == 0) policy_continue = $urandom % 2;
            for (int c = 0; c < 40; c++) begin
                tick        = (($urandom % 3) == 0);
                sample_word = 16'($urandom);
                cmd_save    = (($urandom % 30) == 0);
                cmd_restore = (($urandom % 30) == 0);
                cmd_flush   = (($urandom % 60) == 0);
                ref_switch  = (($urandom % 80) == 0);
                step();
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule